// File: doc/BRIEF.md
# Pipelined Q1.15 Complex Multiplier

This block multiplies two complex operands X and Y. Every real and imaginary part is a 16-bit Q1.15 two's complement fraction. A new product can begin on every clock. Each operand has its own input register with an active-low load enable. Either operand can be conjugated while it is loaded.

Four partial products are formed in parallel and registered. A subtractor then forms the real part and an adder forms the imaginary part, each as a 32-bit Q2.30 word. After that come an optional round bit, a coded shifter that applies the same shift to both parts, and an overflow check for left shifts. The shifted words and the overflow flag are registered.

A combinational selector maps halves of the two 32-bit words onto two 16-bit ports. Changing the selector within one cycle can therefore bring out the whole 64-bit result. Each port has an active-low drive enable, which the block passes on as a drive indication for pad logic outside it.

Top module: `cplx_mul_q15`

## Requirements
- R1: With `ld_x_n` high at a rising clock edge, the X register keeps its value. With `ld_y_n` high, the Y register keeps its value. A register loads only when its enable is low.
- R2: With `conj_x` (or `conj_y`) high at the loading edge, the imaginary part of that operand is negated before it is stored. Negating -1 (16'h8000) gives +32767/32768 (16'h7FFF). The two controls act independently.
- R3: The real result is Xr·Yr − Xi·Yi and the imaginary result is Xr·Yi + Xi·Yr, each a 32-bit Q2.30 word. The result for operands loaded at edge k is in the output registers after edge k+2.
- R4: A partial product of (−1)×(−1) is replaced by the largest positive 31-bit value, 31'h3FFFFFFF in Q1.30.
- R5: With `rnd_en` high during the cycle before the output edge, bit 16 of both 32-bit sums is forced to one. All other bits are unchanged.
- R6: `shf_code` sets the shift for both parts: 2'b11 shifts left by one, 2'b00 applies no shift, 2'b01 shifts right by one and 2'b10 shifts right by two. Right shifts are arithmetic.
- R7: `ovf_flag` is set with the result only when code 2'b11 is used and bits 31 and 30 of the real or the imaginary sum differ before the shift.
- R8: `out_sel` is combinational. 00 puts the upper real half on `port_a` and the upper imaginary half on `port_b`. 01 does the same with the lower halves. 10 puts the real word on `port_a` (upper half) and `port_b` (lower half). 11 does the same with the imaginary word.
- R9: `drv_a` is the inverse of `oe_a_n` and `drv_b` is the inverse of `oe_b_n`, with no clock delay.
- R10: While `rst_n` is low, all registers are cleared, so both ports read zero and `ovf_flag` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ld_x_n | input | 1 | X register load enable, active low |
| ld_y_n | input | 1 | Y register load enable, active low |
| conj_x | input | 1 | Negate X imaginary part on load |
| conj_y | input | 1 | Negate Y imaginary part on load |
| x_re | input | 16 | X real part, Q1.15 |
| x_im | input | 16 | X imaginary part, Q1.15 |
| y_re | input | 16 | Y real part, Q1.15 |
| y_im | input | 16 | Y imaginary part, Q1.15 |
| rnd_en | input | 1 | Force bit 16 of the sums |
| shf_code | input | 2 | Post-shift code |
| out_sel | input | 2 | Output half selector |
| oe_a_n | input | 1 | Port A drive enable, active low |
| oe_b_n | input | 1 | Port B drive enable, active low |
| port_a | output | 16 | First output half |
| port_b | output | 16 | Second output half |
| ovf_flag | output | 1 | Left-shift overflow |
| drv_a | output | 1 | Port A should be driven |
| drv_b | output | 1 | Port B should be driven |

## Verification
The bench targets the -1 corner cases in three places.

- In a (−1)×(−1) partial product, a missing trap would make the real or imaginary part read as a large negative value.
- Conjugating 16'h8000 tests the saturating negation. Without it, the stored value would wrap back to −1.
- With code 11 applied to the doubled trapped value, the overflow flag must rise. A design that tested the wrong bits, or tested after the shift, would either miss this case or flag the safe case where only the real word is trapped.

Holding a load enable high while the data inputs change shows whether a register still captures data it should ignore. Walking all four selector codes on each result shows any swapped halves.

// File: rtl/cplx_mul_q15.sv
module cplx_mul_q15 #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_x_n,
  input  logic          ld_y_n,
  input  logic          conj_x,
  input  logic          conj_y,
  input  logic [DW-1:0] x_re,
  input  logic [DW-1:0] x_im,
  input  logic [DW-1:0] y_re,
  input  logic [DW-1:0] y_im,
  input  logic          rnd_en,
  input  logic [1:0]    shf_code,
  input  logic [1:0]    out_sel,
  input  logic          oe_a_n,
  input  logic          oe_b_n,
  output logic [DW-1:0] port_a,
  output logic [DW-1:0] port_b,
  output logic          ovf_flag,
  output logic          drv_a,
  output logic          drv_b
);
  localparam int PW = 2*DW - 1;
  localparam int SW = 2*DW;
  localparam logic [SW-1:0] SQ_NEG1 = {2'b01, {(SW-2){1'b0}}};
  localparam logic [PW-1:0] PP_MAX  = {1'b0, {(PW-1){1'b1}}};

  function automatic logic [DW-1:0] neg_sat(input logic [DW-1:0] v);
    return (v == {1'b1, {(DW-1){1'b0}}}) ? {1'b0, {(DW-1){1'b1}}} : -v;
  endfunction

  function automatic logic [PW-1:0] trim(input logic [SW-1:0] m);
    return (m == SQ_NEG1) ? PP_MAX : m[PW-1:0];
  endfunction

  function automatic logic [SW-1:0] shifted(input logic [SW-1:0] v, input logic [1:0] c);
    case (c)
      2'b11:   return {v[SW-2:0], 1'b0};
      2'b01:   return {v[SW-1], v[SW-1:1]};
      2'b10:   return {{2{v[SW-1]}}, v[SW-1:2]};
      default: return v;
    endcase
  endfunction

  logic signed [DW-1:0] xr_q, xi_q, yr_q, yi_q;
  logic [PW-1:0] pp_rr, pp_ii, pp_ri, pp_ir;
  logic [SW-1:0] re_q, im_q;
  logic          ovf_q;

  logic signed [SW-1:0] m_rr, m_ii, m_ri, m_ir;
  assign m_rr = SW'(xr_q) * SW'(yr_q);
  assign m_ii = SW'(xi_q) * SW'(yi_q);
  assign m_ri = SW'(xr_q) * SW'(yi_q);
  assign m_ir = SW'(xi_q) * SW'(yr_q);

  logic [SW-1:0] re_sum, im_sum, rnd_bit;
  assign rnd_bit = SW'(rnd_en) << DW;
  assign re_sum  = ({pp_rr[PW-1], pp_rr} - {pp_ii[PW-1], pp_ii}) | rnd_bit;
  assign im_sum  = ({pp_ri[PW-1], pp_ri} + {pp_ir[PW-1], pp_ir}) | rnd_bit;

  logic ovf_nx;
  assign ovf_nx = (shf_code == 2'b11) &&
                  ((re_sum[SW-1] ^ re_sum[SW-2]) || (im_sum[SW-1] ^ im_sum[SW-2]));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xr_q <= '0; xi_q <= '0; yr_q <= '0; yi_q <= '0;
      pp_rr <= '0; pp_ii <= '0; pp_ri <= '0; pp_ir <= '0;
      re_q <= '0; im_q <= '0; ovf_q <= 1'b0;
    end else begin
      if (!ld_x_n) begin
        xr_q <= x_re;
        xi_q <= conj_x ? neg_sat(x_im) : x_im;
      end
      if (!ld_y_n) begin
        yr_q <= y_re;
        yi_q <= conj_y ? neg_sat(y_im) : y_im;
      end
      pp_rr <= trim(m_rr);
      pp_ii <= trim(m_ii);
      pp_ri <= trim(m_ri);
      pp_ir <= trim(m_ir);
      re_q  <= shifted(re_sum, shf_code);
      im_q  <= shifted(im_sum, shf_code);
      ovf_q <= ovf_nx;
    end
  end

  always_comb begin
    case (out_sel)
      2'b00:   begin port_a = re_q[SW-1:DW]; port_b = im_q[SW-1:DW]; end
      2'b01:   begin port_a = re_q[DW-1:0];  port_b = im_q[DW-1:0];  end
      2'b10:   begin port_a = re_q[SW-1:DW]; port_b = re_q[DW-1:0];  end
      default: begin port_a = im_q[SW-1:DW]; port_b = im_q[DW-1:0];  end
    endcase
  end

  assign ovf_flag = ovf_q;
  assign drv_a    = ~oe_a_n;
  assign drv_b    = ~oe_b_n;
endmodule

// File: rtl/cplx_mul_q15_chk.sv
module cplx_mul_q15_chk #(
  parameter int DW = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic            ld_x_n,
  input logic            ld_y_n,
  input logic [1:0]      shf_code,
  input logic            ovf_flag,
  input logic [DW-1:0]   xr_q,
  input logic [DW-1:0]   xi_q,
  input logic [DW-1:0]   yr_q,
  input logic [DW-1:0]   yi_q,
  input logic [2*DW-2:0] pp_rr,
  input logic [2*DW-2:0] pp_ii,
  input logic [2*DW-2:0] pp_ri,
  input logic [2*DW-2:0] pp_ir
);
  localparam logic [2*DW-2:0] PP_MIN = {1'b1, {(2*DW-2){1'b0}}};

  AST_X_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ld_x_n |=> ($stable(xr_q) && $stable(xi_q))); // R1
  AST_Y_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ld_y_n |=> ($stable(yr_q) && $stable(yi_q))); // R1
  AST_NO_WRAPPED_SQUARE: assert property (@(posedge clk) disable iff (!rst_n)
    (pp_rr != PP_MIN) && (pp_ii != PP_MIN) && (pp_ri != PP_MIN) && (pp_ir != PP_MIN)); // R4
  AST_OVF_LEFT_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_flag |-> ($past(shf_code) == 2'b11)); // R7
endmodule

bind cplx_mul_q15 cplx_mul_q15_chk #(.DW(DW)) chk_i (
  .clk(clk), .rst_n(rst_n), .ld_x_n(ld_x_n), .ld_y_n(ld_y_n),
  .shf_code(shf_code), .ovf_flag(ovf_flag),
  .xr_q(xr_q), .xi_q(xi_q), .yr_q(yr_q), .yi_q(yi_q),
  .pp_rr(pp_rr), .pp_ii(pp_ii), .pp_ri(pp_ri), .pp_ir(pp_ir)
);

// File: tb/cplx_mul_q15_tb_top.sv
`timescale 1ns/1ps
module cplx_mul_q15_tb_top;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, ld_x_n, ld_y_n, conj_x, conj_y, rnd_en, oe_a_n, oe_b_n;
  logic [15:0] x_re, x_im, y_re, y_im, port_a, port_b;
  logic [1:0]  shf_code, out_sel;
  logic ovf_flag, drv_a, drv_b;
  wire  [15:0] pad_a = drv_a ? port_a : 16'hzzzz;

  int total = 0;
  int bad = 0;

  cplx_mul_q15 dut_i (
    .clk(clk), .rst_n(rst_n), .ld_x_n(ld_x_n), .ld_y_n(ld_y_n),
    .conj_x(conj_x), .conj_y(conj_y), .x_re(x_re), .x_im(x_im),
    .y_re(y_re), .y_im(y_im), .rnd_en(rnd_en), .shf_code(shf_code),
    .out_sel(out_sel), .oe_a_n(oe_a_n), .oe_b_n(oe_b_n),
    .port_a(port_a), .port_b(port_b), .ovf_flag(ovf_flag),
    .drv_a(drv_a), .drv_b(drv_b)
  );

  // {x_re, x_im, y_re, y_im, conj_x, conj_y, rnd_en, shf_code}
  localparam int NV = 11;
  localparam logic [68:0] VEC [NV] = '{
    {16'h4000, 16'h0000, 16'h4000, 16'h0000, 1'b0, 1'b0, 1'b0, 2'b00},
    {16'h8000, 16'h0000, 16'h8000, 16'h0000, 1'b0, 1'b0, 1'b0, 2'b00},
    {16'h8000, 16'h8000, 16'h8000, 16'h8000, 1'b0, 1'b0, 1'b0, 2'b11},
    {16'h1234, 16'h5678, 16'h9ABC, 16'hDEF0, 1'b0, 1'b0, 1'b0, 2'b00},
    {16'h1234, 16'h5678, 16'h9ABC, 16'hDEF0, 1'b1, 1'b0, 1'b0, 2'b00},
    {16'h1234, 16'h5678, 16'h9ABC, 16'hDEF0, 1'b0, 1'b1, 1'b1, 2'b00},
    {16'h7FFF, 16'h8000, 16'h7FFF, 16'h0000, 1'b1, 1'b0, 1'b0, 2'b01},
    {16'h8001, 16'h7FFF, 16'h0123, 16'h8000, 1'b0, 1'b0, 1'b1, 2'b10},
    {16'h2000, 16'h2000, 16'h2000, 16'hE000, 1'b0, 1'b0, 1'b0, 2'b11},
    {16'h8000, 16'h0000, 16'h8000, 16'h0000, 1'b0, 1'b0, 1'b0, 2'b11},
    {16'h0000, 16'h8000, 16'h0000, 16'h8000, 1'b0, 1'b1, 1'b0, 2'b01}
  };

  function automatic longint pmul(input logic signed [15:0] a, input logic signed [15:0] b);
    if (a == -16'sd32768 && b == -16'sd32768) return (64'sd1 <<< 30) - 1; // R4
    return longint'(a) * longint'(b);
  endfunction

  function automatic logic signed [15:0] cj(input logic signed [15:0] v, input logic c);
    if (!c) return v;
    return (v == -16'sd32768) ? 16'sd32767 : -v; // R2
  endfunction

  // returns {re[31:0], im[31:0], ovf}
  function automatic logic [64:0] model(input logic [68:0] v);
    logic signed [15:0] xr, xi, yr, yi;
    logic signed [31:0] re, im, rs, is;
    logic ov;
    xr = v[68:53]; xi = cj(v[52:37], v[4]);
    yr = v[36:21]; yi = cj(v[20:5], v[3]);
    re = 32'(pmul(xr, yr) - pmul(xi, yi));
    im = 32'(pmul(xr, yi) + pmul(xi, yr));
    if (v[2]) begin re[16] = 1'b1; im[16] = 1'b1; end
    ov = 1'b0;
    case (v[1:0])
      2'b11: begin ov = (re[31] != re[30]) || (im[31] != im[30]); rs = re <<< 1; is = im <<< 1; end
      2'b01: begin rs = re >>> 1; is = im >>> 1; end
      2'b10: begin rs = re >>> 2; is = im >>> 2; end
      default: begin rs = re; is = im; end
    endcase
    return {rs, is, ov};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [68:0] v);
    {x_re, x_im, y_re, y_im, conj_x, conj_y, rnd_en, shf_code} = v;
  endtask

  task automatic check_all(input string req, input logic [64:0] e);
    for (int s = 0; s < 4; s++) begin
      out_sel = 2'(s);
      #0.5;
      case (s)
        0: check({req, " R8 sel00"}, {port_a, port_b}, {e[64:49], e[32:17]});
        1: check({req, " R8 sel01"}, {port_a, port_b}, {e[48:33], e[16:1]});
        2: check({req, " R3 real word"}, {port_a, port_b}, e[64:33]);
        default: check({req, " R3 imag word"}, {port_a, port_b}, e[32:1]);
      endcase
    end
    check({req, " R7 ovf"}, {31'd0, ovf_flag}, {31'd0, e[0]});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [64:0] e;
    rst_n = 1'b0; ld_x_n = 1'b0; ld_y_n = 1'b0; oe_a_n = 1'b0; oe_b_n = 1'b1;
    out_sel = 2'b00;
    apply(VEC[3]);
    repeat (3) @(negedge clk);
    // R10: reset state
    check("R10 ports", {port_a, port_b}, 32'h0);
    check("R10 ovf", {31'd0, ovf_flag}, 32'h0);
    rst_n = 1'b1;

    // R9: drive indications
    #0.5;
    check("R9 drv", {30'd0, drv_a, drv_b}, 32'h2);
    check("R9 pad", {16'h0, pad_a}, {16'h0, port_a});
    oe_a_n = 1'b1; oe_b_n = 1'b0;
    #0.5;
    check("R9 drv swap", {30'd0, drv_a, drv_b}, 32'h1);

    // Vector walk: R2 R3 R4 R5 R6 R7 R8
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      apply(VEC[i]);
      repeat (3) @(negedge clk);
      check_all($sformatf("R2 R4 R5 R6 vec%0d", i), model(VEC[i]));
    end

    // R1: X held while its enable is high
    @(negedge clk);
    apply(VEC[3]);
    @(negedge clk);
    ld_x_n = 1'b1;
    x_re = 16'h7FFF; x_im = 16'h7FFF;
    repeat (3) @(negedge clk);
    check_all("R1 x hold", model(VEC[3]));
    // R1: Y held while X reloads
    ld_x_n = 1'b0; ld_y_n = 1'b1;
    apply(VEC[4]);
    y_re = 16'h0001; y_im = 16'h0001;
    repeat (3) @(negedge clk);
    check_all("R1 y hold", model(VEC[4]));
    ld_y_n = 1'b0;

    // R10: reset during operation clears at once
    @(negedge clk);
    rst_n = 1'b0;
    #0.5;
    out_sel = 2'b10;
    #0.5;
    check("R10 mid-run clear", {port_a, port_b}, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;

    e = model(VEC[2]);
    apply(VEC[2]);
    repeat (3) @(negedge clk);
    check("R4 R7 trap overflow", {31'd0, ovf_flag}, 32'h1);
    check_all("R4 after reset", e);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule